// File: doc/BRIEF.md
# CAN Transmit Frame Assembler

This block accepts register-style word writes for outgoing CAN messages and turns them into complete four-word frames for a transmitter. A message always has four 32-bit words: identifier, length code, first data word and second data word. Two queues use this same layout. One is a normal word FIFO. The other is a small high-priority buffer. Writing the second data word commits a frame. While any frame is committed, the assembler takes the next frame from a queue and presents it on a valid/ready output.

Software is expected to write all four words. If it writes fewer, the frame is not rejected and no error status is raised. The assembler looks at the stored word count modulo four. It treats the missing words as the leading ones and fills each of them from a per-queue shadow copy of the most recent write to that word. A `frm_patched` flag travels with such a frame as an event indication only. A loopback input is captured with each frame, so the downstream logic can send that frame back to the receive side instead of to the bus.

Back-pressure rules:
- The frame output stays valid and unchanged until `frm_ready` is high on a clock edge.
- The assembler pops no word for the next frame before the current frame is accepted.
- The write side has no stall. A write to a full queue is dropped, and the full flag of that queue is provided so the writer can avoid this.

Top module: `can_tx_assembler`

## Requirements
- R1: Word select encoding: 0 = identifier, 1 = length code, 2 = first data, 3 = second data. Queue select encoding: 0 = normal FIFO, 1 = high-priority buffer. When all four words of a queue are written in order, one frame comes out carrying exactly those four values, with `frm_patched` = 0.
- R2: Only a write of the second data word commits a frame. Identifier, length and first-data writes alone never make `frm_valid` rise.
- R3: If the stored word count modulo 4 is 3, the identifier comes from that queue's shadow. The three stored words become length, first data and second data. `frm_patched` = 1.
- R4: If the remainder is 2, the identifier and length come from the shadows. The two stored words become first and second data. `frm_patched` = 1.
- R5: If the remainder is 1, the identifier, length and first data come from the shadows. The single stored word becomes second data. `frm_patched` = 1.
- R6: An incomplete frame raises no status or error output. Its only indication is `frm_patched`, which is held with the frame.
- R7: Each queue keeps its own shadow of identifier, length and first data. The shadows reset to zero and are updated by every write to that queue, including a write that is dropped because the queue is full.
- R8: When both queues hold a committed frame, the high-priority frame is assembled first, and `frm_prio` = 1 marks it.
- R9: While `frm_valid` is high and `frm_ready` is low, every frame output holds its value, and no further frame is taken from a queue.
- R10: Committed frames of a queue are drained one per assembly, in write order, until none remains.
- R11: `frm_loop` equals the `loopback` input at the cycle the frame was assembled.
- R12: A queue's full flag is high exactly when it holds its depth in words, and a word written while full is discarded. After reset, `frm_valid`, both full flags and all frame outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_queue | input | 1 | 0 normal FIFO, 1 high-priority buffer |
| wr_word | input | 2 | Word select (0 id, 1 length, 2 data1, 3 data2) |
| wr_data | input | 32 | Written word |
| loopback | input | 1 | Route assembled frames back to receive path |
| nq_full | output | 1 | Normal FIFO full |
| hp_full | output | 1 | High-priority buffer full |
| frm_valid | output | 1 | Assembled frame available |
| frm_ready | input | 1 | Consumer accepts frame |
| frm_id | output | 32 | Identifier word |
| frm_dlc | output | 32 | Length code word |
| frm_data1 | output | 32 | First data word |
| frm_data2 | output | 32 | Second data word |
| frm_prio | output | 1 | Frame came from the high-priority buffer |
| frm_loop | output | 1 | Frame is to be looped back |
| frm_patched | output | 1 | Frame was completed from shadows |

## Verification
On every cycle the assertions check several properties. The output frame must be held under back-pressure. A frame may rise only after a commit. The high-priority buffer must win an assembly. A queue must never pop more words than it stores, and its count must never exceed its depth. Some behaviours appear only in the bench's scenarios: which stored word lands in which frame field for each remainder, which shadow value fills a missing word, the order of drained frames, and the dropping of writes to a full queue while the shadow still takes the value.

// File: rtl/can_asm_pkg.sv
package can_asm_pkg;
  typedef enum logic [1:0] {
    W_ID   = 2'd0,
    W_DLC  = 2'd1,
    W_DAT1 = 2'd2,
    W_DAT2 = 2'd3
  } word_sel_e;

  localparam int WORDS_PER_FRAME = 4;
  localparam int WORD_W          = 32;

  typedef struct packed {
    logic [WORD_W-1:0] id;
    logic [WORD_W-1:0] dlc;
    logic [WORD_W-1:0] d1;
    logic [WORD_W-1:0] d2;
  } frame_t;
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [W-1:0]   push_data,
  input  logic [2:0]     pop_n,
  output logic [4*W-1:0] head_flat,
  output logic [CW-1:0]  count,
  output logic           full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          push_ok;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + AW'(pop_n);
      count  <= count + CW'(push_ok) - CW'(pop_n);
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_head
    assign head_flat[i*W +: W] = mem[rd_ptr + AW'(i)];
  end

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_n != 3'd0) |-> (CW'(pop_n) <= count));

  assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/shadow_regs.sv
module shadow_regs
  import can_asm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [1:0]   word,
  input  logic [W-1:0] data,
  output logic [W-1:0] sh_id,
  output logic [W-1:0] sh_dlc,
  output logic [W-1:0] sh_d1
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_id  <= '0;
      sh_dlc <= '0;
      sh_d1  <= '0;
    end else if (wr) begin
      case (word_sel_e'(word))
        W_ID:    sh_id  <= data;
        W_DLC:   sh_dlc <= data;
        W_DAT1:  sh_d1  <= data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/frame_builder.sv
module frame_builder
  import can_asm_pkg::*;
(
  input  logic [1:0]          residue,
  input  logic [4*WORD_W-1:0] head_flat,
  input  logic [WORD_W-1:0]   sh_id,
  input  logic [WORD_W-1:0]   sh_dlc,
  input  logic [WORD_W-1:0]   sh_d1,
  output frame_t              frame,
  output logic [2:0]          pop_n,
  output logic                patched
);
  logic [WORD_W-1:0] hw   [4];
  logic [WORD_W-1:0] shv  [4];
  logic [WORD_W-1:0] slot [4];
  logic [2:0]        skip;

  for (genvar i = 0; i < 4; i++) begin : g_split
    assign hw[i] = head_flat[i*WORD_W +: WORD_W];
  end

  assign shv[0] = sh_id;
  assign shv[1] = sh_dlc;
  assign shv[2] = sh_d1;
  assign shv[3] = '0;

  always_comb begin
    patched = (residue != 2'd0);
    skip    = patched ? (3'd4 - {1'b0, residue}) : 3'd0;
    pop_n   = patched ? {1'b0, residue} : 3'd4;
    for (int j = 0; j < 4; j++) begin
      if (3'(j) < skip) slot[j] = shv[j];
      else              slot[j] = hw[2'(j - int'(skip))];
    end
    frame.id  = slot[0];
    frame.dlc = slot[1];
    frame.d1  = slot[2];
    frame.d2  = slot[3];
  end
endmodule

// File: rtl/can_tx_assembler.sv
module can_tx_assembler
  import can_asm_pkg::*;
#(
  parameter int NQ_DEPTH = 16,
  parameter int HP_DEPTH = 4,
  localparam int MAXD    = (NQ_DEPTH > HP_DEPTH) ? NQ_DEPTH : HP_DEPTH,
  localparam int CNTW    = $clog2(MAXD) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_queue,
  input  logic [1:0]  wr_word,
  input  logic [31:0] wr_data,
  input  logic        loopback,
  output logic        nq_full,
  output logic        hp_full,
  output logic        frm_valid,
  input  logic        frm_ready,
  output logic [31:0] frm_id,
  output logic [31:0] frm_dlc,
  output logic [31:0] frm_data1,
  output logic [31:0] frm_data2,
  output logic        frm_prio,
  output logic        frm_loop,
  output logic        frm_patched
);
  logic [CNTW-1:0]     cnt_w  [2];
  logic [CNTW-1:0]     cmt_w  [2];
  logic [4*WORD_W-1:0] head_w [2];
  logic [WORD_W-1:0]   shi_w  [2];
  logic [WORD_W-1:0]   shl_w  [2];
  logic [WORD_W-1:0]   shd_w  [2];
  logic                full_w [2];
  logic                rdy_w  [2];

  logic       sel, go, out_free, b_patched;
  logic [2:0] b_pop;
  frame_t     b_frame, out_frame;

  for (genvar q = 0; q < 2; q++) begin : g_queue
    localparam int DQ = (q == 1) ? HP_DEPTH : NQ_DEPTH;
    localparam int QW = $clog2(DQ) + 1;
    logic          push, d2_commit, taken;
    logic [QW-1:0] cnt_l;

    assign push      = wr_en && (wr_queue == 1'(q));
    assign d2_commit = push && !full_w[q] && (wr_word == W_DAT2);
    assign taken     = go && (sel == 1'(q));
    assign cnt_w[q]  = CNTW'(cnt_l);
    assign rdy_w[q]  = (cmt_w[q] != '0) && (cnt_w[q] != '0);

    word_fifo #(.W(WORD_W), .DEPTH(DQ)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(wr_data),
      .pop_n(taken ? b_pop : 3'd0), .head_flat(head_w[q]),
      .count(cnt_l), .full(full_w[q])
    );

    shadow_regs #(.W(WORD_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .wr(push), .word(wr_word), .data(wr_data),
      .sh_id(shi_w[q]), .sh_dlc(shl_w[q]), .sh_d1(shd_w[q])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmt_w[q] <= '0;
      else        cmt_w[q] <= cmt_w[q] + CNTW'(d2_commit) - CNTW'(taken);
    end
  end

  assign nq_full  = full_w[0];
  assign hp_full  = full_w[1];
  assign out_free = !frm_valid || frm_ready;
  assign sel      = rdy_w[1];
  assign go       = out_free && (rdy_w[0] || rdy_w[1]);

  frame_builder u_build (
    .residue(cnt_w[sel][1:0]), .head_flat(head_w[sel]),
    .sh_id(shi_w[sel]), .sh_dlc(shl_w[sel]), .sh_d1(shd_w[sel]),
    .frame(b_frame), .pop_n(b_pop), .patched(b_patched)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_valid   <= 1'b0;
      out_frame   <= '0;
      frm_prio    <= 1'b0;
      frm_loop    <= 1'b0;
      frm_patched <= 1'b0;
    end else if (go) begin
      frm_valid   <= 1'b1;
      out_frame   <= b_frame;
      frm_prio    <= sel;
      frm_loop    <= loopback;
      frm_patched <= b_patched;
    end else if (frm_ready) begin
      frm_valid   <= 1'b0;
    end
  end

  assign frm_id    = out_frame.id;
  assign frm_dlc   = out_frame.dlc;
  assign frm_data1 = out_frame.d1;
  assign frm_data2 = out_frame.d2;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_id) && $stable(frm_dlc)
      && $stable(frm_data1) && $stable(frm_data2) && $stable(frm_prio)
      && $stable(frm_patched)));

  assert_prio_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmt_w[1] != '0) |=> frm_prio);

  assert_commit_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_valid) |-> ($past(cmt_w[0]) != '0 || $past(cmt_w[1]) != '0));
endmodule

// File: tb/sim_can_tx_assembler.sv
module sim_can_tx_assembler;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_queue = 1'b0, loopback = 1'b0, frm_ready = 1'b0;
  logic [1:0]  wr_word = 2'd0;
  logic [31:0] wr_data = '0;
  logic        nq_full, hp_full, frm_valid, frm_prio, frm_loop, frm_patched;
  logic [31:0] frm_id, frm_dlc, frm_data1, frm_data2;

  int checks = 0, failures = 0;
  logic [31:0] shm [2][3];
  logic [31:0] g_id, g_dlc, g_d1, g_d2;
  logic        g_prio, g_loop, g_patch, g_ok;

  always #2.5 clk = ~clk;

  can_tx_assembler u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_queue(wr_queue), .wr_word(wr_word),
    .wr_data(wr_data), .loopback(loopback), .nq_full(nq_full), .hp_full(hp_full),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_id(frm_id), .frm_dlc(frm_dlc),
    .frm_data1(frm_data1), .frm_data2(frm_data2), .frm_prio(frm_prio),
    .frm_loop(frm_loop), .frm_patched(frm_patched)
  );

  // vector: [11:4] seed, [2:1] leading words skipped, [0] queue
  localparam logic [11:0] VEC [8] = '{
    {8'h11, 1'b0, 2'd3, 1'b1}, {8'h22, 1'b0, 2'd0, 1'b0},
    {8'h33, 1'b0, 2'd1, 1'b0}, {8'h44, 1'b0, 2'd2, 1'b0},
    {8'h55, 1'b0, 2'd3, 1'b0}, {8'h66, 1'b0, 2'd0, 1'b1},
    {8'h77, 1'b0, 2'd2, 1'b1}, {8'h88, 1'b0, 2'd1, 1'b1}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic q, input logic [1:0] w, input logic [31:0] d);
    wr_en = 1'b1; wr_queue = q; wr_word = w; wr_data = d;
    if (w != 2'd3) shm[q][w] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic take();
    int t = 0;
    while (!frm_valid && t < 50) begin @(negedge clk); t++; end
    g_ok = frm_valid;
    g_id = frm_id; g_dlc = frm_dlc; g_d1 = frm_data1; g_d2 = frm_data2;
    g_prio = frm_prio; g_loop = frm_loop; g_patch = frm_patched;
    frm_ready = 1'b1;
    @(negedge clk);
    frm_ready = 1'b0;
  endtask

  function automatic logic [31:0] pat(input logic [7:0] s, input logic q, input int w);
    return {s, 7'd0, q, 8'(w), 8'hA5};
  endfunction

  task automatic full_frame(input logic q, input logic [7:0] s);
    for (int w = 0; w < 4; w++) wr(q, 2'(w), pat(s, q, w));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] exp [4];
    logic [31:0] got [4];
    for (int q = 0; q < 2; q++) for (int w = 0; w < 3; w++) shm[q][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!frm_valid && !nq_full && !hp_full, "R12 reset flags",
        {29'd0, frm_valid, nq_full, hp_full}, 32'd0);
    chk(frm_id == 0 && frm_data2 == 0, "R12 reset frame", frm_id | frm_data2, 32'd0);

    // table of partial / complete frames (R1 R3 R4 R5 R6 R7)
    for (int v = 0; v < 8; v++) begin
      logic       q = VEC[v][0];
      int         k = int'(VEC[v][2:1]);
      logic [7:0] s = VEC[v][11:4];
      for (int w = 0; w < 4; w++)
        exp[w] = (w < k) ? shm[q][w] : pat(s, q, w);
      for (int w = k; w < 4; w++) wr(q, 2'(w), pat(s, q, w));
      take();
      got[0] = g_id; got[1] = g_dlc; got[2] = g_d1; got[3] = g_d2;
      chk(g_ok, "R1 frame present", {31'd0, g_ok}, 32'd1);
      for (int w = 0; w < 4; w++)
        chk(got[w] == exp[w], (k == 0) ? "R1 word" : (k == 1) ? "R3 word" :
            (k == 2) ? "R4 word" : "R5 word/R7 shadow", got[w], exp[w]);
      chk(g_patch == (k != 0), "R6 patched flag", {31'd0, g_patch}, {31'd0, k != 0});
      chk(g_prio == q, "R8 prio tag", {31'd0, g_prio}, {31'd0, q});
    end

    // R2: no frame before the second data word
    wr(1'b0, 2'd0, 32'hC0DE_0000); wr(1'b0, 2'd1, 32'hC0DE_0001);
    wr(1'b0, 2'd2, 32'hC0DE_0002);
    repeat (8) @(negedge clk);
    chk(!frm_valid, "R2 no commit yet", {31'd0, frm_valid}, 32'd0);
    wr(1'b0, 2'd3, 32'hC0DE_0003);
    take();
    chk(g_ok && g_id == 32'hC0DE_0000 && g_d2 == 32'hC0DE_0003, "R2 committed", g_id, 32'hC0DE_0000);

    // R9 hold, R8 priority, R10 order
    full_frame(1'b0, 8'hA0);
    full_frame(1'b0, 8'hB0);
    full_frame(1'b1, 8'hC0);
    repeat (4) @(negedge clk);
    chk(frm_valid && frm_id == pat(8'hA0, 1'b0, 0), "R9 held frame", frm_id, pat(8'hA0, 1'b0, 0));
    take();
    take();
    chk(g_prio && g_id == pat(8'hC0, 1'b1, 0), "R8 high priority first", g_id, pat(8'hC0, 1'b1, 0));
    take();
    chk(!g_prio && g_id == pat(8'hB0, 1'b0, 0), "R10 then normal", g_id, pat(8'hB0, 1'b0, 0));

    // R12 full, R7 shadow takes dropped write, R10 drain order
    full_frame(1'b0, 8'h10);
    for (int f = 1; f <= 4; f++) full_frame(1'b0, 8'(8'h10 + f));
    chk(nq_full, "R12 full flag", {31'd0, nq_full}, 32'd1);
    wr(1'b0, 2'd0, 32'hBAD1_0000);
    chk(nq_full, "R12 still full", {31'd0, nq_full}, 32'd1);
    for (int f = 0; f <= 4; f++) begin
      take();
      chk(g_ok && g_id == pat(8'(8'h10 + f), 1'b0, 0), "R10 drain order", g_id,
          pat(8'(8'h10 + f), 1'b0, 0));
    end
    repeat (5) @(negedge clk);
    chk(!frm_valid && !nq_full, "R12 dropped word left nothing",
        {30'd0, frm_valid, nq_full}, 32'd0);
    wr(1'b0, 2'd1, 32'h0000_0D1C); wr(1'b0, 2'd2, 32'h0000_DA7A);
    wr(1'b0, 2'd3, 32'h0000_DA7B);
    take();
    chk(g_id == 32'hBAD1_0000 && g_patch, "R7 shadow from dropped write", g_id, 32'hBAD1_0000);

    // R11 loopback
    loopback = 1'b1;
    full_frame(1'b1, 8'hE0);
    take();
    chk(g_loop, "R11 loop set", {31'd0, g_loop}, 32'd1);
    loopback = 1'b0;
    full_frame(1'b1, 8'hE1);
    take();
    chk(!g_loop, "R11 loop clear", {31'd0, g_loop}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule